// File: doc/BRIEF.md
# Trigger-Latency Circular Hit Buffer

Each pixel keeps a ring of hit words, one slot per bunch crossing. On every crossing clock edge the block writes the incoming hit word into the current slot. The slot being overwritten holds the word written exactly one full lap earlier, so every stored crossing is read at a fixed latency of one lap. The default lap is 120 crossings, which is 3 us at a 40 MHz crossing rate.

The level-1 trigger decision for the crossing being read arrives on `trig_i` in the same cycle as the read. An accepted crossing leaves the pixel as a valid word carrying its slot index as a crossing tag. A rejected crossing is dropped and its slot is reused by the new write. No hit is examined before its trigger decision, which keeps the per-hit work to one write and one read.

Top module: `trig_latency_hitbuf`

## Requirements
- R1: While `rst_ni` is low, `valid_o`, `hit_o` and `tag_o` are all zero, and every slot and the slot pointer are cleared.
- R2: `tag_o` is registered and always shows the index of the slot read at the last edge. The index starts at 0 after reset, rises by one per crossing and wraps from DEPTH-1 (119) to 0.
- R3: A hit word written at crossing n is read at crossing n+DEPTH. The read takes place before that slot is overwritten in the same cycle.
- R4: If `trig_i` is low at a crossing, `valid_o` is 0 and `hit_o` is all zeros after that edge.
- R5: If `trig_i` is high at a crossing after the first lap, then after that edge `valid_o` is 1, `hit_o` holds the word stored in the slot being read, and `tag_o` holds that slot's index.
- R6: During the first DEPTH crossings after reset, `valid_o` stays 0 even when `trig_i` is high.
- R7: A trigger on a slot whose stored word is zero still produces `valid_o` = 1, with `hit_o` all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bunch-crossing clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hit_i | input | HIT_W (8) | Hit word of the current crossing |
| trig_i | input | 1 | Level-1 accept for the slot being read this crossing |
| valid_o | output | 1 | Accepted crossing present on the output |
| hit_o | output | HIT_W (8) | Stored hit word of the accepted crossing, zero otherwise |
| tag_o | output | TAG_W (7) | Slot index of the crossing just read |

## Verification
In the first lap the trigger is held high on every crossing. This tells a correctly gated startup apart from one that releases cleared slots as data. In the second lap the trigger is again high on every crossing and every stored word is nonzero, so an off-by-one latency, a write-before-read ordering or a wrong tag shows up on each crossing. Later laps use sparse random triggers and mix in zero hit words. These separate a discarded crossing from a forwarded one and check that an empty slot is still reported as valid.

// File: rtl/hitbuf_pkg.sv
package hitbuf_pkg;
  localparam int unsigned DEPTH = 120;
  localparam int unsigned HIT_W = 8;
  localparam int unsigned TAG_W = $clog2(DEPTH);
endpackage

// File: rtl/hitbuf_ring_ptr.sv
module hitbuf_ring_ptr #(
  parameter int unsigned DEPTH = hitbuf_pkg::DEPTH,
  localparam int unsigned TAG_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [TAG_W-1:0] ptr_o,
  output logic             lap_done_o
);
  localparam logic [TAG_W-1:0] LAST = TAG_W'(DEPTH - 1);

  logic [TAG_W-1:0] ptr_q;
  logic             lap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
      lap_q <= 1'b0;
    end else begin
      ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
      if (ptr_q == LAST) lap_q <= 1'b1;
    end
  end

  assign ptr_o      = ptr_q;
  assign lap_done_o = lap_q;

  assert_ptr_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_q <= LAST);
  assert_ptr_wrap_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_q == LAST |=> ptr_q == '0);
  assert_ptr_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_q != LAST |=> ptr_q == $past(ptr_q) + 1'b1);
  assert_lap_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lap_q |=> lap_q);
endmodule

// File: rtl/hitbuf_slot_array.sv
module hitbuf_slot_array #(
  parameter int unsigned DEPTH = hitbuf_pkg::DEPTH,
  parameter int unsigned HIT_W = hitbuf_pkg::HIT_W,
  localparam int unsigned TAG_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [TAG_W-1:0] idx_i,
  input  logic [HIT_W-1:0] wr_data_i,
  output logic [HIT_W-1:0] rd_data_o
);
  logic [HIT_W-1:0] slot_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                   slot_q[g] <= '0;
      else if (idx_i == TAG_W'(g))   slot_q[g] <= wr_data_i;
    end
  end

  // old contents are read combinationally, so the read precedes the write
  always_comb begin
    rd_data_o = '0;
    for (int i = 0; i < DEPTH; i++)
      if (idx_i == TAG_W'(i)) rd_data_o = slot_q[i];
  end
endmodule

// File: rtl/hitbuf_readout.sv
module hitbuf_readout #(
  parameter int unsigned DEPTH = hitbuf_pkg::DEPTH,
  parameter int unsigned HIT_W = hitbuf_pkg::HIT_W,
  localparam int unsigned TAG_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             trig_i,
  input  logic             lap_done_i,
  input  logic [TAG_W-1:0] idx_i,
  input  logic [HIT_W-1:0] rd_data_i,
  output logic             valid_o,
  output logic [HIT_W-1:0] hit_o,
  output logic [TAG_W-1:0] tag_o
);
  logic accept;
  assign accept = trig_i & lap_done_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      hit_o   <= '0;
      tag_o   <= '0;
    end else begin
      valid_o <= accept;
      hit_o   <= accept ? rd_data_i : '0;
      tag_o   <= idx_i;
    end
  end

  assert_drop_untrig_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !trig_i |=> !valid_o && hit_o == '0);
  assert_first_lap_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lap_done_i |=> !valid_o);
  assert_forward_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_i && lap_done_i |=> valid_o && hit_o == $past(rd_data_i) && tag_o == $past(idx_i));
  assert_idle_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> hit_o == '0);
endmodule

// File: rtl/trig_latency_hitbuf.sv
module trig_latency_hitbuf #(
  parameter int unsigned DEPTH = hitbuf_pkg::DEPTH,
  parameter int unsigned HIT_W = hitbuf_pkg::HIT_W,
  localparam int unsigned TAG_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [HIT_W-1:0] hit_i,
  input  logic             trig_i,
  output logic             valid_o,
  output logic [HIT_W-1:0] hit_o,
  output logic [TAG_W-1:0] tag_o
);
  logic [TAG_W-1:0] ptr;
  logic             lap_done;
  logic [HIT_W-1:0] rd_data;

  hitbuf_ring_ptr #(.DEPTH(DEPTH)) u_ptr (
    .clk_i(clk_i), .rst_ni(rst_ni), .ptr_o(ptr), .lap_done_o(lap_done)
  );

  hitbuf_slot_array #(.DEPTH(DEPTH), .HIT_W(HIT_W)) u_slots (
    .clk_i(clk_i), .rst_ni(rst_ni), .idx_i(ptr), .wr_data_i(hit_i), .rd_data_o(rd_data)
  );

  hitbuf_readout #(.DEPTH(DEPTH), .HIT_W(HIT_W)) u_out (
    .clk_i(clk_i), .rst_ni(rst_ni), .trig_i(trig_i), .lap_done_i(lap_done),
    .idx_i(ptr), .rd_data_i(rd_data),
    .valid_o(valid_o), .hit_o(hit_o), .tag_o(tag_o)
  );

  assert_reset_out_R1: assert property (@(posedge clk_i) !rst_ni |-> !valid_o && hit_o == '0 && tag_o == '0);
endmodule

// File: tb/trig_latency_hitbuf_tb_top.sv
`timescale 1ns/1ps
module trig_latency_hitbuf_tb_top;
  localparam int DEPTH = 120;
  localparam int HIT_W = 8;
  localparam int TAG_W = 7;
  localparam int MAXC  = 1024;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic [HIT_W-1:0] hit_i = '0;
  logic             trig_i = 1'b0;
  logic             valid_o;
  logic [HIT_W-1:0] hit_o;
  logic [TAG_W-1:0] tag_o;

  int errors = 0;
  int checks = 0;
  int crossing = 0;
  logic [HIT_W-1:0] hist [MAXC];
  bit done = 0;

  always #2.5 clk_i = ~clk_i;

  trig_latency_hitbuf dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .hit_i(hit_i), .trig_i(trig_i),
    .valid_o(valid_o), .hit_o(hit_o), .tag_o(tag_o)
  );

  function automatic logic exp_valid(int c, logic t);
    return t && (c > DEPTH);
  endfunction

  function automatic logic [HIT_W-1:0] exp_hit(int c, logic t);
    if (!exp_valid(c, t)) return '0;
    return hist[c - DEPTH];
  endfunction

  function automatic logic [TAG_W-1:0] exp_tag(int c);
    return TAG_W'((c - 1) % DEPTH);
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s crossing=%0d actual=%0h expected=%0h", req, crossing, act, exp);
    end
  endtask

  // drive at negedge, edge, sample at next negedge
  task automatic step(logic [HIT_W-1:0] h, logic t, string vreq);
    hit_i  = h;
    trig_i = t;
    @(posedge clk_i);
    crossing++;
    hist[crossing] = h;
    @(negedge clk_i);
    chk(vreq, int'(valid_o), int'(exp_valid(crossing, t)));
    chk(t ? ((crossing > DEPTH && exp_hit(crossing, t) == '0) ? "R7" : "R3/R5") : "R4",
        int'(hit_o), int'(exp_hit(crossing, t)));
    chk("R2", int'(tag_o), int'(exp_tag(crossing)));
  endtask

  initial begin
    #100000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog crossing=%0d actual=hung expected=finish", crossing);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    #12;
    chk("R1", int'(valid_o), 0);
    chk("R1", int'(hit_o), 0);
    chk("R1", int'(tag_o), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    // first lap: trigger always high, must stay invalid (R6)
    for (int i = 0; i < DEPTH; i++) step(HIT_W'($urandom_range(1, 255)), 1'b1, "R6");
    // second lap: all triggered, checks latency and ordering (R3, R5)
    for (int i = 0; i < DEPTH; i++) step(HIT_W'($urandom_range(1, 255)), 1'b1, "R5");
    // sparse triggers, some zero hits (R4, R7)
    for (int i = 0; i < 4 * DEPTH; i++) begin
      logic t = ($urandom_range(0, 7) == 0);
      logic [HIT_W-1:0] h = ($urandom_range(0, 3) == 0) ? '0 : HIT_W'($urandom);
      step(h, t, t ? "R5" : "R4");
    end
    // directed: dense run of triggers over zero words one lap earlier (R7)
    for (int i = 0; i < DEPTH; i++) step('0, 1'b0, "R4");
    for (int i = 0; i < 8; i++) step(HIT_W'(8'hA0 + i), 1'b1, "R7");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule